// File: doc/BRIEF.md
# Dot-Clock Output Divider Generator

This block takes the pixel-rate dot clock and derives three slower outputs from it: a reference output, a shift output and a video output. Each output is produced in the dot-clock domain as two signals. The first is a one-cycle enable pulse that marks the end of each divided period. The second is a registered-state square wave with 50% duty at the divided rate. Downstream logic can use the enables as clock enables, or forward the square waves.

Two configuration registers control the block. The output-divider register holds a 3-bit log2 ratio code for each output. A ratio code takes effect on its channel only at that channel's next terminal count, so a change never produces a shortened pulse. The source-select register records which input clock the system has chosen and reports it back. The block does not switch clocks itself.

The blank input is synchronous to the dot clock. It silences and rewinds the shift and video channels. The reference channel ignores blank and keeps running.

Top module: `dotclk_divgen`

## Requirements
- R1: While rst_ni is low, and just after reset, every ratio code is 0 and src_sel_o is 0. Every counter starts at phase 0, so ref_en_o and ref_clk_o are high, and the shift and video outputs are high when blank_i is low.
- R2: div_i holds three 3-bit codes k: bits [2:0] for reference, [5:3] for shift and [8:6] for video. For a channel with code k, en is high for exactly one cycle in every 2^k dot-clock cycles. That cycle is the last one of the period, counting from phase 0.
- R3: For k of 1 or more, the channel's clock output is low for the first 2^(k-1) cycles of each period and high for the last 2^(k-1) cycles. The enable cycle always falls inside the high half. For k = 0, the clock output is held high.
- R4: A code of 7 divides by 64, the same as code 6.
- R5: When div_we_i is high at a clock edge, div_i is stored at that edge. A channel switches to its stored code only in the edge that ends its current period, or in an edge where it is held by blank. The period in progress always completes at its old length.
- R6: The reference channel's counter, enable and clock output ignore blank_i.
- R7: While blank_i is high, shf_en_o, shf_clk_o, vid_en_o and vid_clk_o are low in the same cycle. Both counters are held at phase 0 and take their stored codes. Counting restarts from phase 0 in the first cycle with blank_i low.
- R8: When src_we_i is high at a clock edge, src_sel_o shows src_i from that edge onward. Without a write, src_sel_o holds its value.
- R9: With code 0, the channel's enable is high on every dot-clock cycle (except for shift and video while blanked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blank_i | input | 1 | Blank, gates shift and video channels |
| src_we_i | input | 1 | Source-select register write strobe |
| src_i | input | 3 | Source-select write data |
| div_we_i | input | 1 | Output-divider register write strobe |
| div_i | input | 9 | Ratio codes: [2:0] reference, [5:3] shift, [8:6] video |
| src_sel_o | output | 3 | Reported source selection |
| ref_en_o | output | 1 | Reference enable pulse |
| ref_clk_o | output | 1 | Reference 50% duty output |
| shf_en_o | output | 1 | Shift enable pulse |
| shf_clk_o | output | 1 | Shift 50% duty output |
| vid_en_o | output | 1 | Video enable pulse |
| vid_clk_o | output | 1 | Video 50% duty output |

## Verification
All outputs are decoded combinationally from counter and ratio registers, so a register write or a count step becomes visible in the cycle after the edge that captures it. A ratio write needs one edge to reach the stored register and then waits for the channel's terminal edge. A change on blank_i reaches the shift and video outputs in the same cycle. The bench steps its behavioural model at each rising edge from inputs that were driven at the falling edge. It compares all seven outputs 3 ns after that rising edge, when the design's registers and the blank gating have settled. Directed windows also count enable pulses and high cycles over whole periods, to check ratio and duty independently of phase.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // channel indices inside the ratio register
  typedef enum int unsigned {
    CH_REF = 0,
    CH_SHF = 1,
    CH_VID = 2
  } dcd_ch_e;

  localparam int unsigned NUM_CH = 3;

  // saturate a log2 ratio code at the largest supported exponent
  function automatic logic [2:0] dcd_clamp(input logic [2:0] code,
                                           input int unsigned max_log2);
    logic [2:0] lim;
    lim = 3'(max_log2);
    return (code > lim) ? lim : code;
  endfunction

endpackage

// File: rtl/dcd_cfg_regs.sv
module dcd_cfg_regs #(
  parameter int unsigned SRC_W    = 3,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned LOG2_MAX = 6,
  localparam int unsigned SEL_W   = NUM_CH * CODE_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             src_we_i,
  input  logic [SRC_W-1:0]                 src_i,
  input  logic                             div_we_i,
  input  logic [SEL_W-1:0]                 div_i,
  output logic [SRC_W-1:0]                 src_q_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]    code_o
);
  import dcd_pkg::*;

  logic [SRC_W-1:0] src_q, src_d;
  logic [SEL_W-1:0] div_q, div_d;

  // next state with explicit write enables
  always_comb begin
    src_d = src_q;
    div_d = div_q;
    if (src_we_i) src_d = src_i;
    if (div_we_i) div_d = div_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      div_q <= '0;
    end else begin
      src_q <= src_d;
      div_q <= div_d;
    end
  end

  assign src_q_o = src_q;

  // per-channel decode with saturation of out-of-range codes
  for (genvar c = 0; c < NUM_CH; c++) begin : g_code
    assign code_o[c] = CODE_W'(dcd_clamp(3'(div_q[c*CODE_W +: CODE_W]), LOG2_MAX));
  end

endmodule

// File: rtl/dcd_div_chan.sv
module dcd_div_chan #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned LOG2_MAX = 6,
  parameter bit          GATED    = 1'b1,
  localparam int unsigned CNT_W   = (LOG2_MAX > 0) ? LOG2_MAX : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic              tick_clk_o
);

  localparam logic GATE_BIT = GATED;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] k_q, k_d;
  logic [CNT_W-1:0]  mask;
  logic [CNT_W-1:0]  top_bit;
  logic              term;
  logic              hold;
  logic              upper;

  // blank only reaches gated channels
  assign hold = blank_i & GATE_BIT;

  // period mask, terminal detect and upper-half detect
  always_comb begin
    mask    = CNT_W'((32'd1 << k_q) - 32'd1);
    top_bit = mask & ~(mask >> 1);
    term    = (cnt_q == mask);
    upper   = (k_q == '0) | (|(cnt_q & top_bit));
  end

  // next state: ratio is loaded only at a period boundary or while held
  always_comb begin
    cnt_d = cnt_q + 1'b1;
    k_d   = k_q;
    if (hold || term) begin
      cnt_d = '0;
      k_d   = code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      k_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      k_q   <= k_d;
    end
  end

  assign en_o       = term  & ~hold;
  assign tick_clk_o = upper & ~hold;

endmodule

// File: rtl/dotclk_divgen.sv
module dotclk_divgen #(
  parameter int unsigned SRC_W    = 3,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned LOG2_MAX = 6,
  localparam int unsigned NCH     = 3,
  localparam int unsigned SEL_W   = NCH * CODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blank_i,
  input  logic             src_we_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             div_we_i,
  input  logic [SEL_W-1:0] div_i,
  output logic [SRC_W-1:0] src_sel_o,
  output logic             ref_en_o,
  output logic             ref_clk_o,
  output logic             shf_en_o,
  output logic             shf_clk_o,
  output logic             vid_en_o,
  output logic             vid_clk_o
);
  import dcd_pkg::*;

  logic [NCH-1:0][CODE_W-1:0] code_w;
  logic [NCH-1:0]             en_w;
  logic [NCH-1:0]             clk_w;

  dcd_cfg_regs #(
    .SRC_W   (SRC_W),
    .CODE_W  (CODE_W),
    .NUM_CH  (NCH),
    .LOG2_MAX(LOG2_MAX)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_we_i(src_we_i),
    .src_i   (src_i),
    .div_we_i(div_we_i),
    .div_i   (div_i),
    .src_q_o (src_sel_o),
    .code_o  (code_w)
  );

  // channel 0 is free running, the others obey blank
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dcd_div_chan #(
      .CODE_W  (CODE_W),
      .LOG2_MAX(LOG2_MAX),
      .GATED   (c != int'(CH_REF))
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .blank_i   (blank_i),
      .code_i    (code_w[c]),
      .en_o      (en_w[c]),
      .tick_clk_o(clk_w[c])
    );
  end

  assign ref_en_o  = en_w[CH_REF];
  assign ref_clk_o = clk_w[CH_REF];
  assign shf_en_o  = en_w[CH_SHF];
  assign shf_clk_o = clk_w[CH_SHF];
  assign vid_en_o  = en_w[CH_VID];
  assign vid_clk_o = clk_w[CH_VID];

endmodule

// File: rtl/dotclk_divgen_chk.sv
module dotclk_divgen_chk #(
  parameter int unsigned SRC_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_i,
  input logic             src_we_i,
  input logic [SRC_W-1:0] src_i,
  input logic [SRC_W-1:0] src_sel_o,
  input logic             ref_en_o,
  input logic             ref_clk_o,
  input logic             shf_en_o,
  input logic             shf_clk_o,
  input logic             vid_en_o,
  input logic             vid_clk_o
);

  // enable always lands inside the high half
  assert_ref_en_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> ref_clk_o);

  // no runt: the free output only falls right after a terminal cycle
  assert_ref_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_clk_o) |-> $past(ref_en_o));

  assert_shf_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shf_clk_o) |-> (blank_i || $past(shf_en_o)));

  assert_vid_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vid_clk_o) |-> (blank_i || $past(vid_en_o)));

  assert_blank_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> !(shf_en_o || shf_clk_o || vid_en_o || vid_clk_o));

  assert_src_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_we_i |=> (src_sel_o == $past(src_i)));

  assert_src_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_we_i |=> $stable(src_sel_o));

endmodule

bind dotclk_divgen dotclk_divgen_chk #(.SRC_W(SRC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .blank_i  (blank_i),
  .src_we_i (src_we_i),
  .src_i    (src_i),
  .src_sel_o(src_sel_o),
  .ref_en_o (ref_en_o),
  .ref_clk_o(ref_clk_o),
  .shf_en_o (shf_en_o),
  .shf_clk_o(shf_clk_o),
  .vid_en_o (vid_en_o),
  .vid_clk_o(vid_clk_o)
);

// File: tb/dotclk_divgen_bench.sv
`timescale 1ns/1ps
module dotclk_divgen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       blank;
  logic       src_we;
  logic [2:0] src_d;
  logic       div_we;
  logic [8:0] div_d;
  logic [2:0] src_sel;
  logic ref_en, ref_clk, shf_en, shf_clk, vid_en, vid_clk;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt [3];
  int m_k   [3];
  int m_sel [3];
  int m_src;

  always #5 clk = ~clk;

  dotclk_divgen u_dotclk_divgen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .blank_i  (blank),
    .src_we_i (src_we),
    .src_i    (src_d),
    .div_we_i (div_we),
    .div_i    (div_d),
    .src_sel_o(src_sel),
    .ref_en_o (ref_en),
    .ref_clk_o(ref_clk),
    .shf_en_o (shf_en),
    .shf_clk_o(shf_clk),
    .vid_en_o (vid_en),
    .vid_clk_o(vid_clk)
  );

  function automatic int sat(input int code);
    return (code > 6) ? 6 : code;
  endfunction

  function automatic bit held(input int c);
    return (c != 0) && (blank === 1'b1);
  endfunction

  function automatic bit exp_en(input int c);
    if (held(c)) return 1'b0;
    return m_cnt[c] == (1 << m_k[c]) - 1;
  endfunction

  function automatic bit exp_clk(input int c);
    if (held(c)) return 1'b0;
    if (m_k[c] == 0) return 1'b1;
    return m_cnt[c] >= (1 << (m_k[c] - 1));
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_cnt[c] = 0; m_k[c] = 0; m_sel[c] = 0;
    end
    m_src = 0;
  endtask

  task automatic model_step();
    for (int c = 0; c < 3; c++) begin
      if (held(c) || (m_cnt[c] == (1 << m_k[c]) - 1)) begin
        m_cnt[c] = 0;
        m_k[c]   = sat(m_sel[c]);
      end else begin
        m_cnt[c] = m_cnt[c] + 1;
      end
    end
    if (div_we) for (int c = 0; c < 3; c++) m_sel[c] = int'(div_d[c*3 +: 3]);
    if (src_we) m_src = int'(src_d);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("src_sel", int'(src_sel), m_src);
    chk("ref_en",  int'(ref_en),  int'(exp_en(0)));
    chk("ref_clk", int'(ref_clk), int'(exp_clk(0)));
    chk("shf_en",  int'(shf_en),  int'(exp_en(1)));
    chk("shf_clk", int'(shf_clk), int'(exp_clk(1)));
    chk("vid_en",  int'(vid_en),  int'(exp_en(2)));
    chk("vid_clk", int'(vid_clk), int'(exp_clk(2)));
  endtask

  initial model_reset();

  // model advances on each edge; outputs compared once settled
  always @(posedge clk) begin
    if (rst_n !== 1'b1) model_reset();
    else model_step();
    #3;
    compare_all();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_div(input int r, input int s, input int v);
    @(negedge clk);
    div_we = 1'b1;
    div_d  = {3'(v), 3'(s), 3'(r)};
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_src(input int v);
    @(negedge clk);
    src_we = 1'b1;
    src_d  = 3'(v);
    @(negedge clk);
    src_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; blank = 1'b0; src_we = 1'b0; src_d = '0;
    div_we = 1'b0; div_d = '0;
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(3);

    cur_req = "R9";
    idle(5);

    cur_req = "R8";
    wr_src(2); idle(3);
    wr_src(5); idle(3);

    cur_req = "R2";
    wr_div(2, 1, 3);
    idle(40);

    cur_req = "R5";
    idle(1);
    wr_div(5, 1, 3);
    idle(150);

    cur_req = "R4";
    wr_div(7, 7, 7);
    idle(130);
    cnt = 0;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #3;
      if (ref_en === 1'b1) cnt++;
    end
    chk("R4 ref pulses in 256 cycles", cnt, 4);

    cur_req = "R3";
    wr_div(3, 2, 0);
    idle(130);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #3;
      if (ref_clk === 1'b1) cnt++;
    end
    chk("R3 ref high cycles in 64", cnt, 32);

    cur_req = "R7";
    wr_div(1, 2, 4);
    idle(7);
    @(negedge clk); blank = 1'b1;
    idle(20);
    @(negedge clk); blank = 1'b0;
    idle(50);
    @(negedge clk); blank = 1'b1;
    @(negedge clk); blank = 1'b0;
    idle(30);

    cur_req = "R6";
    wr_div(2, 0, 0);
    @(negedge clk); blank = 1'b1;
    idle(40);
    @(negedge clk); blank = 1'b0;
    idle(10);

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      blank  = ($urandom_range(0, 9) == 0);
      div_we = ($urandom_range(0, 29) == 0);
      div_d  = 9'($urandom);
      src_we = ($urandom_range(0, 19) == 0);
      src_d  = 3'($urandom);
    end
    @(negedge clk);
    blank = 1'b0; div_we = 1'b0; src_we = 1'b0;
    idle(5);

    finish_run();
  end

endmodule